// File: doc/BRIEF.md
# Shift-Register LIFO Stack

This block is a five-entry, 8-bit last-in-first-out store. It has no address pointer. The data moves through a fixed chain of registers instead. A push loads the new word into the top stage, and in the same cycle every occupied stage hands its word one step deeper. A pop moves every stage one step toward the top, and a zero enters at the bottom.

The output is wired straight to the top stage, so the next word to leave is always visible without a request. A pop strobe consumes that word at the clock edge. An internal occupancy count from 0 to 5 drives the empty and full flags. A push and a pop may arrive in any cycle, including the same cycle.

Top module: `lifo_shift_stack`

## Requirements
- R1: The stack holds at most 5 words of 8 bits. `empty` is 1 exactly when 0 words are held, and `full` is 1 exactly when 5 words are held.
- R2: A push alone, on a stack that is not full, makes `dout` equal to the pushed word from the next cycle and raises the count by one.
- R3: Words leave in the reverse of the order in which they were pushed.
- R4: A pop alone, on a stack that is not empty, removes the top word. From the next cycle `dout` shows the word pushed before it, or 0 if none is left, and the count falls by one.
- R5: A push alone while full is ignored. The count and all stored words stay unchanged.
- R6: A pop alone while empty is ignored. `empty` stays 1 and `dout` stays 0.
- R7: A push and a pop together, on a stack that is not empty, do the following:
  - `dout` shows the old top word in that cycle.
  - The top word is replaced by the new word.
  - The deeper words and the count are unchanged.
- R8: A push and a pop together on an empty stack act as a push alone.
- R9: A synchronous reset (`rst` = 1 at a clock edge) empties the stack, and `dout` becomes 0.
- R10: `dout` follows the top stage combinationally in every cycle. It reads 0 whenever the stack is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Store `din` on top of the stack |
| pop | input | 1 | Consume the word on `dout` |
| din | input | 8 | Word to push |
| dout | output | 8 | Current top word, 0 when empty |
| full | output | 1 | Five words held |
| empty | output | 1 | No word held |

## Verification
The two functions that can fall in the same cycle are the push and the pop. Their overlap is provoked on an empty stack, a partly filled stack and a full stack, both in directed steps and in a long pseudo-random stream of strobes. In each case a queue-based model decides whether the result is a replacement of the top, a plain push, or an ignored request. Every cycle the model's top word and flags are compared against `dout`, `full` and `empty`.

// File: rtl/lifo_shift_stack.sv
module lifo_shift_stack #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] stage [DEPTH];
  logic [CW-1:0]    count;
  logic             do_rep, do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_rep  = push && pop && !empty;
  assign do_push = push && !do_rep && !full;
  assign do_pop  = pop && !push && !empty;
  assign dout    = stage[0];

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (do_push)
      count <= count + 1'b1;
    else if (do_pop)
      count <= count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      stage[0] <= '0;
    else if (do_push || do_rep)
      stage[0] <= din;
    else if (do_pop)
      stage[0] <= (DEPTH > 1) ? stage[1 % DEPTH] : '0;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    logic [WIDTH-1:0] below;
    if (i == DEPTH - 1) begin : g_last
      assign below = '0;
    end else begin : g_mid
      assign below = stage[i+1];
    end
    always_ff @(posedge clk) begin
      if (rst)
        stage[i] <= '0;
      else if (do_push)
        stage[i] <= stage[i-1];
      else if (do_pop)
        stage[i] <= below;
    end
  end
endmodule

module lifo_shift_stack_chk #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             push,
  input logic             pop,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] dout,
  input logic             full,
  input logic             empty
);
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst) !(full && empty)); // R1
  AST_PUSH_TOP: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !full) |=> (dout == $past(din)) && !empty); // R2
  AST_POP_LAST_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !empty && $past(push && !pop && empty)) |=> empty); // R4
  AST_FULL_PUSH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && full) |=> full && $stable(dout)); // R5
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && empty) |=> empty); // R6
  AST_REPLACE_TOP: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !empty) |=> (dout == $past(din)) && $stable(full) && $stable(empty)); // R7
  AST_EMPTY_PUSHPOP: assert property (@(posedge clk) disable iff (rst)
    (push && pop && empty) |=> !empty && (dout == $past(din))); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> empty && (dout == '0)); // R9
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst) empty |-> dout == '0); // R10
endmodule

bind lifo_shift_stack lifo_shift_stack_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/lifo_shift_stack_bench.sv
module lifo_shift_stack_bench;
  logic clk = 1'b0;
  logic rst = 1'b1, push = 1'b0, pop = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic full, empty;
  int checks = 0, failures = 0;
  logic [7:0] q[$];
  logic done = 1'b0;

  always #2 clk = ~clk;

  lifo_shift_stack u_lifo_shift_stack (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .din(din),
    .dout(dout), .full(full), .empty(empty)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "dout", dout, (q.size() == 0) ? 0 : q[0]);
    chk(tag, "empty", empty, q.size() == 0);
    chk(tag, "full", full, q.size() == 5);
  endtask

  task automatic step(string tag, logic r, logic p, logic po, logic [7:0] d);
    rst = r; push = p; pop = po; din = d;
    #1 compare(tag);
    @(posedge clk);
    if (r) q.delete();
    else if (p && po && q.size() > 0) q[0] = d;
    else if (p && q.size() < 5) q.push_front(d);
    else if (po && !p && q.size() > 0) void'(q.pop_front());
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] lfsr = 8'h5A;
    @(negedge clk);
    step("R9", 1, 0, 0, 0);
    compare("R9");
    for (int i = 0; i < 5; i++) step("R2", 0, 1, 0, 8'h10 + 8'(i));
    compare("R1");
    step("R5", 0, 1, 0, 8'hEE);
    step("R5", 0, 1, 0, 8'hEF);
    compare("R5");
    for (int i = 0; i < 5; i++) step("R3", 0, 0, 1, 0);
    compare("R4");
    step("R6", 0, 0, 1, 0);
    step("R6", 0, 0, 1, 0);
    compare("R10");
    step("R8", 0, 1, 1, 8'h77);
    compare("R8");
    step("R2", 0, 1, 0, 8'h21);
    step("R7", 0, 1, 1, 8'h99);
    compare("R7");
    step("R4", 0, 0, 1, 0);
    compare("R4");
    for (int i = 0; i < 4; i++) step("R2", 0, 1, 0, 8'h30 + 8'(i));
    step("R7", 0, 1, 1, 8'hAB);
    compare("R7");
    for (int i = 0; i < 6; i++) step("R3", 0, 0, 1, 0);
    for (int i = 0; i < 3; i++) step("R2", 0, 1, 0, 8'h40 + 8'(i));
    step("R9", 1, 0, 0, 0);
    compare("R9");
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step("R3", 0, lfsr[0] | lfsr[3], lfsr[1], lfsr ^ 8'(i));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule